// File: doc/BRIEF.md
# Dual-Lane Compare and Branch Condition Unit

This unit serves the flag path of a small vector program sequencer. When a compare instruction issues, the unit compares the x lanes and the y lanes of two single-precision operands. Each lane uses its own 3-bit comparison code taken from the instruction word. The two outcomes are stored as a pair of condition flags.

Flow-control instructions read those flags through a separate combinational path. Each flag is tested against a reference bit carried in the branch instruction. The two match results are merged by a 2-bit join operation into one condition-true output.

Floating-point ordering is done on sign-magnitude keys, so positive and negative zero compare equal. NaN inputs receive no special treatment. A start strobe clears both flags at the beginning of every program run.

Top module: `vcc_top`

## Requirements
- R1: Per lane, compare code 0 gives a==b, 1 gives a!=b, 2 gives a<b, 3 gives a<=b, 4 gives a>b and 5 gives a>=b, with a and b being IEEE single-precision values.
- R2: Compare codes 6 and 7 always produce a false lane result.
- R3: The x-lane code is taken from compare-word bits 26:24 and its result goes to flags_o[0]. The y-lane code is taken from bits 23:21 and its result goes to flags_o[1].
- R4: The flags load the two lane results on a rising clock edge where cmp_en_i is high. On any other edge they keep their value.
- R5: Positive zero and negative zero compare as equal.
- R6: Values are ordered by sign and magnitude. Every negative non-zero value is below every positive value, and a larger magnitude is lower among negatives.
- R7: The x match is true when branch-word bit 25 equals flags_o[0]. The y match is true when branch-word bit 24 equals flags_o[1].
- R8: The join operation is in branch-word bits 23:22. Its values are 0 = OR of both matches, 1 = AND of both matches, 2 = x match only and 3 = y match only.
- R9: A high start_i clears both flags on the next edge and overrides a simultaneous cmp_en_i.
- R10: Synchronous active-high reset clears both flags.
- R11: cond_o is combinational from the current flags and the branch word, with no register in its path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Program-start strobe; clears the flags |
| cmp_en_i | input | 1 | Compare strobe; loads the flags |
| cmp_word_i | input | 32 | Compare instruction word (lane codes) |
| ax_i | input | 32 | Operand A, x lane |
| bx_i | input | 32 | Operand B, x lane |
| ay_i | input | 32 | Operand A, y lane |
| by_i | input | 32 | Operand B, y lane |
| br_word_i | input | 32 | Branch instruction word (references, join op) |
| flags_o | output | 2 | Condition flags {y, x} |
| cond_o | output | 1 | Branch condition result |

## Verification
A compare result appears on flags_o exactly one rising edge after the cycle in which cmp_en_i or start_i is high. The bench drives these strobes on a falling edge and reads flags_o on the next falling edge, after exactly one register stage. cond_o has no register in its path, so the bench changes br_word_i and reads cond_o one nanosecond later, within the same cycle. It also confirms that flags_o does not move when no strobe is present.

// File: rtl/vcc_pkg.sv
package vcc_pkg;

    localparam int LANE_W    = 32;
    localparam int WORD_W    = 32;
    localparam int CODE_W    = 3;
    localparam int JOIN_W    = 2;
    localparam int NUM_LANES = 2;
    localparam int KEY_W     = LANE_W + 1;

    // field positions decoded from instruction words
    localparam int XCODE_LO = 24;
    localparam int YCODE_LO = 21;
    localparam int XREF_BIT = 25;
    localparam int YREF_BIT = 24;
    localparam int JOIN_LO  = 22;

    typedef enum logic [CODE_W-1:0] {
        CMP_EQ   = 3'd0,
        CMP_NE   = 3'd1,
        CMP_LT   = 3'd2,
        CMP_LE   = 3'd3,
        CMP_GT   = 3'd4,
        CMP_GE   = 3'd5,
        CMP_RSV6 = 3'd6,
        CMP_RSV7 = 3'd7
    } cmp_code_e;

    typedef enum logic [JOIN_W-1:0] {
        JOIN_ANY = 2'd0,
        JOIN_ALL = 2'd1,
        JOIN_X   = 2'd2,
        JOIN_Y   = 2'd3
    } join_op_e;

    typedef struct packed {
        cmp_code_e code_y;
        cmp_code_e code_x;
    } cmp_ctl_t;

    typedef struct packed {
        logic     ref_y;
        logic     ref_x;
        join_op_e join_op;
    } br_ctl_t;

    // signed ordering key: sign-magnitude mapped so that -0 == +0
    function automatic logic signed [KEY_W-1:0] order_key(input logic [LANE_W-1:0] v);
        logic signed [KEY_W-1:0] mag;
        mag = {2'b00, v[LANE_W-2:0]};
        return v[LANE_W-1] ? -mag : mag;
    endfunction

    function automatic cmp_ctl_t decode_cmp(input logic [WORD_W-1:0] w);
        cmp_ctl_t c;
        c.code_x = cmp_code_e'(w[XCODE_LO +: CODE_W]);
        c.code_y = cmp_code_e'(w[YCODE_LO +: CODE_W]);
        return c;
    endfunction

    function automatic br_ctl_t decode_br(input logic [WORD_W-1:0] w);
        br_ctl_t b;
        b.ref_x   = w[XREF_BIT];
        b.ref_y   = w[YREF_BIT];
        b.join_op = join_op_e'(w[JOIN_LO +: JOIN_W]);
        return b;
    endfunction

endpackage

// File: rtl/vcc_lane_cmp.sv
module vcc_lane_cmp
    import vcc_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  cmp_code_e    code_i,
    output logic         hit_o
);

    logic signed [W:0] key_a;
    logic signed [W:0] key_b;
    logic              is_eq;
    logic              is_lt;

    always_comb begin
        key_a = order_key(a_i);
        key_b = order_key(b_i);
        is_eq = (key_a == key_b);
        is_lt = (key_a < key_b);
        unique case (code_i)
            CMP_EQ:  hit_o = is_eq;
            CMP_NE:  hit_o = !is_eq;
            CMP_LT:  hit_o = is_lt;
            CMP_LE:  hit_o = is_lt || is_eq;
            CMP_GT:  hit_o = !is_lt && !is_eq;
            CMP_GE:  hit_o = !is_lt;
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/vcc_flag_reg.sv
module vcc_flag_reg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         we_i,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            q_o <= '0;
        end else if (we_i) begin
            q_o <= d_i;
        end
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !we_i) |=> $stable(q_o));

    assert_start_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (q_o == '0));

endmodule

// File: rtl/vcc_branch_eval.sv
module vcc_branch_eval
    import vcc_pkg::*;
(
    input  logic [NUM_LANES-1:0] flags_i,
    input  br_ctl_t              ctl_i,
    output logic                 cond_o
);

    logic match_x;
    logic match_y;

    always_comb begin
        match_x = (ctl_i.ref_x == flags_i[0]);
        match_y = (ctl_i.ref_y == flags_i[1]);
        unique case (ctl_i.join_op)
            JOIN_ANY: cond_o = match_x || match_y;
            JOIN_ALL: cond_o = match_x && match_y;
            JOIN_X:   cond_o = match_x;
            JOIN_Y:   cond_o = match_y;
            default:  cond_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/vcc_top.sv
module vcc_top
    import vcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cmp_en_i,
    input  logic [WORD_W-1:0] cmp_word_i,
    input  logic [LANE_W-1:0] ax_i,
    input  logic [LANE_W-1:0] bx_i,
    input  logic [LANE_W-1:0] ay_i,
    input  logic [LANE_W-1:0] by_i,
    input  logic [WORD_W-1:0] br_word_i,
    output logic [1:0]        flags_o,
    output logic              cond_o
);

    cmp_ctl_t                cmp_ctl;
    br_ctl_t                 br_ctl;
    logic [LANE_W-1:0]       op_a  [NUM_LANES];
    logic [LANE_W-1:0]       op_b  [NUM_LANES];
    cmp_code_e               codes [NUM_LANES];
    logic [NUM_LANES-1:0]    lane_hit;
    logic [NUM_LANES-1:0]    flag_q;

    always_comb begin
        cmp_ctl  = decode_cmp(cmp_word_i);
        br_ctl   = decode_br(br_word_i);
        op_a[0]  = ax_i;
        op_b[0]  = bx_i;
        op_a[1]  = ay_i;
        op_b[1]  = by_i;
        codes[0] = cmp_ctl.code_x;
        codes[1] = cmp_ctl.code_y;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        vcc_lane_cmp #(.W(LANE_W)) u_lane (
            .a_i    (op_a[g]),
            .b_i    (op_b[g]),
            .code_i (codes[g]),
            .hit_o  (lane_hit[g])
        );
    end

    vcc_flag_reg #(.N(NUM_LANES)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .clr_i (start_i),
        .we_i  (cmp_en_i),
        .d_i   (lane_hit),
        .q_o   (flag_q)
    );

    vcc_branch_eval u_branch (
        .flags_i (flag_q),
        .ctl_i   (br_ctl),
        .cond_o  (cond_o)
    );

    assign flags_o = flag_q;

    // reserved codes never set a flag
    assert_reserved_code_R2: assert property (@(posedge clk) disable iff (rst)
        (cmp_en_i && !start_i && cmp_word_i[XCODE_LO +: CODE_W] >= 3'd6) |=> !flags_o[0]);

    // signed zeros are equal
    assert_zero_equal_R5: assert property (@(posedge clk) disable iff (rst)
        (cmp_en_i && !start_i && cmp_word_i[XCODE_LO +: CODE_W] == 3'd0 &&
         ax_i[LANE_W-2:0] == '0 && bx_i[LANE_W-2:0] == '0) |=> flags_o[0]);

    // negative non-zero is below any positive
    assert_sign_order_R6: assert property (@(posedge clk) disable iff (rst)
        (cmp_en_i && !start_i && cmp_word_i[XCODE_LO +: CODE_W] == 3'd2 &&
         ax_i[LANE_W-1] && ax_i[LANE_W-2:0] != '0 && !bx_i[LANE_W-1]) |=> flags_o[0]);

    // AND join true only when both references match
    assert_join_all_R8: assert property (@(posedge clk) disable iff (rst)
        (br_word_i[JOIN_LO +: JOIN_W] == 2'd1 && cond_o) |->
        (flags_o[0] == br_word_i[XREF_BIT] && flags_o[1] == br_word_i[YREF_BIT]));

endmodule

// File: tb/vcc_top_tb.sv
`timescale 1ns/1ps
module vcc_top_tb;

    localparam int NV = 12;
    localparam logic [31:0] P0 = 32'h0000_0000, N0 = 32'h8000_0000;
    localparam logic [31:0] P1 = 32'h3F80_0000, N1 = 32'hBF80_0000;
    localparam logic [31:0] P2 = 32'h4000_0000, N2 = 32'hC000_0000;
    localparam logic [31:0] PH = 32'h3F00_0000;

    // {code_x, code_y, ax, bx, ay, by, expected {y,x}}
    localparam logic [135:0] VEC [NV] = '{
        {3'd0, 3'd1, P1, P1, P1, P2, 2'b11},
        {3'd2, 3'd3, P1, P2, P2, P1, 2'b01},
        {3'd4, 3'd5, P2, P1, P1, P1, 2'b11},
        {3'd4, 3'd2, N1, N2, N2, N1, 2'b11},
        {3'd2, 3'd4, N1, P1, N1, P1, 2'b01},
        {3'd0, 3'd1, P0, N0, P0, N0, 2'b01},
        {3'd2, 3'd5, N0, P0, N0, P0, 2'b10},
        {3'd6, 3'd7, P1, P1, P1, P1, 2'b00},
        {3'd1, 3'd0, P1, P1, PH, PH, 2'b10},
        {3'd3, 3'd3, N2, N2, PH, N1, 2'b01},
        {3'd5, 3'd4, N2, PH, P2, PH, 2'b10},
        {3'd2, 3'd2, PH, P1, P1, PH, 2'b01}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        cmp_en_i = 1'b0;
    logic [31:0] cmp_word_i = '0;
    logic [31:0] ax_i = '0, bx_i = '0, ay_i = '0, by_i = '0;
    logic [31:0] br_word_i = '0;
    logic [1:0]  flags_o;
    logic        cond_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vcc_top u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .cmp_en_i(cmp_en_i),
        .cmp_word_i(cmp_word_i), .ax_i(ax_i), .bx_i(bx_i), .ay_i(ay_i), .by_i(by_i),
        .br_word_i(br_word_i), .flags_o(flags_o), .cond_o(cond_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] cx, input logic [2:0] cy,
                        input logic [31:0] a0, input logic [31:0] b0,
                        input logic [31:0] a1, input logic [31:0] b1, input bit en);
        @(negedge clk);
        cmp_word_i = {5'b0, cx, cy, 21'h0};
        ax_i = a0; bx_i = b0; ay_i = a1; by_i = b1;
        cmp_en_i = en;
        @(posedge clk);
        @(negedge clk);
        cmp_en_i = 1'b0;
    endtask

    // force flags to {fy,fx} using EQ (true) or code 6 (false) on equal operands
    task automatic set_flags(input bit fy, input bit fx);
        load(fx ? 3'd0 : 3'd6, fy ? 3'd0 : 3'd6, P1, P1, P1, P1, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk("R10 reset flags", 32'(flags_o), 32'h0);
        br_word_i = {6'b0, 1'b0, 1'b0, 2'd1, 22'h0};
        #1 chk("R10 cond after reset", 32'(cond_o), 32'h1);

        // R1 R3 R5 R6 R2: vector table
        for (int i = 0; i < NV; i++) begin
            load(VEC[i][135:133], VEC[i][132:130], VEC[i][129:98], VEC[i][97:66],
                 VEC[i][65:34], VEC[i][33:2], 1'b1);
            chk($sformatf("R1 R3 vector %0d", i), 32'(flags_o), 32'(VEC[i][1:0]));
        end

        // R4: no load without strobe
        set_flags(1'b0, 1'b1);
        load(3'd0, 3'd0, P1, P1, P1, P1, 1'b0);
        chk("R4 hold without strobe", 32'(flags_o), 32'h1);
        repeat (3) @(negedge clk);
        chk("R4 hold idle cycles", 32'(flags_o), 32'h1);

        // R9: start clears and wins over compare
        set_flags(1'b1, 1'b1);
        @(negedge clk);
        start_i = 1'b1;
        cmp_en_i = 1'b1;
        cmp_word_i = {5'b0, 3'd0, 3'd0, 21'h0};
        ax_i = P1; bx_i = P1; ay_i = P1; by_i = P1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        cmp_en_i = 1'b0;
        chk("R9 start priority clear", 32'(flags_o), 32'h0);

        // R7 R8 R11: condition over all flag states, refs and ops
        for (int f = 0; f < 4; f++) begin
            set_flags(f[1], f[0]);
            for (int op = 0; op < 4; op++) begin
                for (int r = 0; r < 4; r++) begin
                    bit mx, my, ex;
                    br_word_i = {6'b0, r[1], r[0], op[1:0], 22'h0};
                    mx = (r[1] == f[0]);
                    my = (r[0] == f[1]);
                    case (op)
                        0: ex = mx | my;
                        1: ex = mx & my;
                        2: ex = mx;
                        default: ex = my;
                    endcase
                    #1 chk($sformatf("R7 R8 R11 f=%0d op=%0d r=%0d", f, op, r),
                           32'(cond_o), 32'(ex));
                end
            end
        end

        // R10: reset mid-run
        set_flags(1'b1, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset mid-run", 32'(flags_o), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule